// File: doc/BRIEF.md
# Framed Byte Receive DMA Channel

This block is a single receive channel that pulls bytes out of a peripheral data register and writes them into memory. Each byte is taken with a request/acknowledge handshake. Each byte goes to the next address above a start address that software programs. The channel can delimit variable-length messages in three ways, and a mode register selects which one applies:

- **Padded-block mode.** The channel always produces a block of fixed size. Once the source flags the end of a message, the channel pads the rest of the block with a constant fill byte.
- **Length-prefix mode.** The first byte received is a length. The channel consumes that byte itself, then receives exactly that many payload bytes.
- **Open-count mode.** Software programs a count larger than any message. It then reads back how many bytes have arrived so far, because the count is normally never exhausted.

Software drives the channel through a small word-addressed register bus. It writes the mode, the start address and the count limit, and it issues command strobes (arm, stop, clear). It reads back a status word and the running payload byte count. A sticky interrupt line tells the processor that a transfer has completed.

Top module: `rx_dma_framer`

## Requirements
- R1: After reset the channel is idle. Every register reads zero, `irq` is low, and `mem_we` and `src_ack` are low.
- R2: The register map is as follows.
  - Address 0 holds the mode code: 0 = padded block, 1 = length prefix, 2 = open count. A written value with bit 1 set reads back as 2. Otherwise bit 0 selects 1 or 0.
  - Address 1 is the start address.
  - Address 2 is the count limit.
  - Address 3 reads status: bit0 busy, bit1 interrupt, bit2 length byte consumed, bit3 rearm error. A write to address 3 acts as a command: bit0 arm, bit1 stop, bit2 clear interrupt and error.
  - Address 4 reads the payload byte count.
- R3: In padded-block mode a transfer writes exactly BLOCK bytes (256 by default). Source bytes are written until one arrives with `src_eom` set. After that, FILL bytes are written on consecutive cycles without any acknowledge, until the block is full. The interrupt is then set.
- R4: In padded-block mode, a message that fills the whole block without `src_eom` completes after BLOCK source bytes with no fill bytes and sets the interrupt.
- R5: In length-prefix mode:
  - The first accepted byte is not written to memory. It sets the status bit2 flag.
  - Exactly that many following bytes are then written.
  - The interrupt is set only once, after the last payload byte.
  - A length of zero completes at once, with no memory write.
- R6: In open-count mode the channel writes source bytes and ignores `src_eom`. It sets the interrupt only when the count limit is used up, so a message shorter than the limit leaves the channel busy with the interrupt low.
- R7: The payload count increments by one for each source byte written to memory. Arming clears it. Reading it mid-transfer does not alter the transfer.
- R8: Memory writes start at the start address and the address rises by one for each byte written, including fill bytes.
- R9: An arm command while the channel is busy is ignored: the transfer and its byte count continue unchanged, and status bit3 is set. A clear command lowers the interrupt and bit3.
- R10: A stop command returns a busy channel to idle without setting the interrupt.
- R11: `src_ack` is high only in a cycle where `src_req` is high and the channel is waiting for a source byte. It is never high while idle or while padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| src_req | input | 1 | Source has a byte ready |
| src_data | input | 8 | Source byte |
| src_eom | input | 1 | Byte offered is the last of its message |
| src_ack | output | 1 | Byte taken at the coming clock edge |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The assertions assume the following about the environment:
- The memory port accepts a write in every cycle.
- The source holds its byte, end flag and request steady until the acknowledge comes.
- A single command write never asks for both stop and arm.

The bench keeps to these assumptions:
- Memory is modelled as a sink that captures every write.
- The source driver releases a byte only after seeing the acknowledge, with optional idle gaps between bytes.
- Each command word carries a single action bit.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    typedef enum logic [1:0] {
        FRAME_FIXED  = 2'd0,
        FRAME_LENGTH = 2'd1,
        FRAME_OVER   = 2'd2
    } frame_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEN  = 2'd1,
        PH_RECV = 2'd2,
        PH_PAD  = 2'd3
    } phase_e;

    localparam logic [2:0] REG_MODE  = 3'd0;
    localparam logic [2:0] REG_BASE  = 3'd1;
    localparam logic [2:0] REG_LIMIT = 3'd2;
    localparam logic [2:0] REG_CTRL  = 3'd3;
    localparam logic [2:0] REG_XFER  = 3'd4;

    localparam int CMD_ARM   = 0;
    localparam int CMD_STOP  = 1;
    localparam int CMD_CLEAR = 2;

endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs
    import rxdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          st_busy,
    input  logic          st_irq,
    input  logic          st_len_done,
    input  logic          st_err,
    input  logic [CW-1:0] st_xfer,
    output frame_e        mode,
    output logic [AW-1:0] base,
    output logic [CW-1:0] limit,
    output logic          arm_stb,
    output logic          stop_stb,
    output logic          clr_stb
);

    typedef struct packed {
        frame_e        mode;
        logic [AW-1:0] base;
        logic [CW-1:0] limit;
    } regs_t;

    localparam regs_t REGS_RST = '{mode: FRAME_FIXED, base: '0, limit: '0};

    regs_t regs_d, regs_q;
    logic  ctrl_hit;
    logic  unused_wdata;

    assign unused_wdata = ^cfg_wdata;
    assign ctrl_hit = cfg_we && (cfg_addr == REG_CTRL);
    assign arm_stb  = ctrl_hit && cfg_wdata[CMD_ARM];
    assign stop_stb = ctrl_hit && cfg_wdata[CMD_STOP];
    assign clr_stb  = ctrl_hit && cfg_wdata[CMD_CLEAR];

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            case (cfg_addr)
                REG_MODE: begin
                    if (cfg_wdata[1])      regs_d.mode = FRAME_OVER;
                    else if (cfg_wdata[0]) regs_d.mode = FRAME_LENGTH;
                    else                   regs_d.mode = FRAME_FIXED;
                end
                REG_BASE:  regs_d.base  = cfg_wdata[AW-1:0];
                REG_LIMIT: regs_d.limit = cfg_wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_MODE:  cfg_rdata = DW'(regs_q.mode);
            REG_BASE:  cfg_rdata = DW'(regs_q.base);
            REG_LIMIT: cfg_rdata = DW'(regs_q.limit);
            REG_CTRL:  cfg_rdata = DW'({st_err, st_len_done, st_irq, st_busy});
            REG_XFER:  cfg_rdata = DW'(st_xfer);
            default:   cfg_rdata = '0;
        endcase
    end

    assign mode  = regs_q.mode;
    assign base  = regs_q.base;
    assign limit = regs_q.limit;

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
    import rxdma_pkg::*;
#(
    parameter int         AW    = 16,
    parameter int         CW    = 16,
    parameter int         BLOCK = 256,
    parameter logic [7:0] FILL  = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  frame_e        mode,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] limit,
    input  logic          arm_stb,
    input  logic          stop_stb,
    input  logic          clr_stb,
    input  logic          src_req,
    input  logic [7:0]    src_data,
    input  logic          src_eom,
    output logic          src_ack,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          busy,
    output logic          irq,
    output logic          len_done,
    output logic          err,
    output logic [CW-1:0] xfer
);

    localparam logic [CW-1:0] BLOCK_C = CW'(BLOCK);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    typedef struct packed {
        phase_e        ph;
        frame_e        mode;
        logic [AW-1:0] addr;
        logic [CW-1:0] rem;
        logic [CW-1:0] xfer;
        logic          irq;
        logic          err;
        logic          len_done;
    } eng_t;

    localparam eng_t ENG_RST = '{ph: PH_IDLE, mode: FRAME_FIXED, addr: '0,
                                 rem: '0, xfer: '0, irq: 1'b0, err: 1'b0,
                                 len_done: 1'b0};

    eng_t eng_d, eng_q;
    logic waiting;
    logic padding;

    assign waiting = (eng_q.ph == PH_RECV) || (eng_q.ph == PH_LEN);
    assign padding = (eng_q.ph == PH_PAD);

    always_comb begin
        eng_d = eng_q;
        if (clr_stb) begin
            eng_d.irq = 1'b0;
            eng_d.err = 1'b0;
        end
        case (eng_q.ph)
            PH_RECV: begin
                if (src_req) begin
                    eng_d.addr = eng_q.addr + 1'b1;
                    eng_d.xfer = eng_q.xfer + 1'b1;
                    eng_d.rem  = eng_q.rem - 1'b1;
                    if (eng_q.rem == ONE_C) begin
                        eng_d.ph  = PH_IDLE;
                        eng_d.irq = 1'b1;
                    end else if (eng_q.mode == FRAME_FIXED && src_eom) begin
                        eng_d.ph = PH_PAD;
                    end
                end
            end
            PH_PAD: begin
                eng_d.addr = eng_q.addr + 1'b1;
                eng_d.rem  = eng_q.rem - 1'b1;
                if (eng_q.rem == ONE_C) begin
                    eng_d.ph  = PH_IDLE;
                    eng_d.irq = 1'b1;
                end
            end
            PH_LEN: begin
                if (src_req) begin
                    eng_d.len_done = 1'b1;
                    if (src_data == 8'd0) begin
                        eng_d.ph  = PH_IDLE;
                        eng_d.irq = 1'b1;
                    end else begin
                        eng_d.ph  = PH_RECV;
                        eng_d.rem = CW'(src_data);
                    end
                end
            end
            default: ;
        endcase
        if (stop_stb) begin
            eng_d.ph = PH_IDLE;
        end else if (arm_stb) begin
            if (eng_q.ph != PH_IDLE) begin
                eng_d.err = 1'b1;
            end else begin
                eng_d.mode     = mode;
                eng_d.addr     = base;
                eng_d.xfer     = '0;
                eng_d.len_done = 1'b0;
                case (mode)
                    FRAME_LENGTH: eng_d.ph = PH_LEN;
                    FRAME_OVER: begin
                        eng_d.rem = limit;
                        if (limit == '0) begin
                            eng_d.ph  = PH_IDLE;
                            eng_d.irq = 1'b1;
                        end else begin
                            eng_d.ph = PH_RECV;
                        end
                    end
                    default: begin
                        eng_d.rem = BLOCK_C;
                        eng_d.ph  = PH_RECV;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= ENG_RST;
        else        eng_q <= eng_d;
    end

    assign src_ack   = waiting && src_req;
    assign mem_we    = padding || (eng_q.ph == PH_RECV && src_req);
    assign mem_addr  = eng_q.addr;
    assign mem_wdata = padding ? FILL : src_data;
    assign busy      = (eng_q.ph != PH_IDLE);
    assign irq       = eng_q.irq;
    assign len_done  = eng_q.len_done;
    assign err       = eng_q.err;
    assign xfer      = eng_q.xfer;

endmodule

// File: rtl/rx_dma_framer.sv
module rx_dma_framer
    import rxdma_pkg::*;
#(
    parameter int         AW    = 16,
    parameter int         CW    = 16,
    parameter int         BLOCK = 256,
    parameter logic [7:0] FILL  = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          src_req,
    input  logic [7:0]    src_data,
    input  logic          src_eom,
    output logic          src_ack,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          irq
);

    frame_e        cur_mode;
    logic [AW-1:0] cur_base;
    logic [CW-1:0] cur_limit;
    logic          arm_stb, stop_stb, clr_stb;
    logic          eng_busy, eng_irq, eng_len_done, eng_err;
    logic [CW-1:0] eng_xfer;

    rxdma_regs #(.AW(AW), .CW(CW), .DW(32)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .st_busy     (eng_busy),
        .st_irq      (eng_irq),
        .st_len_done (eng_len_done),
        .st_err      (eng_err),
        .st_xfer     (eng_xfer),
        .mode        (cur_mode),
        .base        (cur_base),
        .limit       (cur_limit),
        .arm_stb     (arm_stb),
        .stop_stb    (stop_stb),
        .clr_stb     (clr_stb)
    );

    rxdma_engine #(.AW(AW), .CW(CW), .BLOCK(BLOCK), .FILL(FILL)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cur_mode),
        .base      (cur_base),
        .limit     (cur_limit),
        .arm_stb   (arm_stb),
        .stop_stb  (stop_stb),
        .clr_stb   (clr_stb),
        .src_req   (src_req),
        .src_data  (src_data),
        .src_eom   (src_eom),
        .src_ack   (src_ack),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (eng_busy),
        .irq       (eng_irq),
        .len_done  (eng_len_done),
        .err       (eng_err),
        .xfer      (eng_xfer)
    );

    assign irq = eng_irq;

endmodule

// File: rtl/rxdma_checker.sv
module rxdma_checker #(
    parameter int         AW   = 16,
    parameter int         CW   = 16,
    parameter logic [7:0] FILL = 8'hA5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [2:0]    cfg_addr,
    input logic [1:0]    cmd_bits,
    input logic          src_req,
    input logic          src_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata,
    input logic          irq,
    input logic          busy,
    input logic [CW-1:0] xfer,
    input logic          len_done,
    input logic          err
);

    logic arm_cmd;
    assign arm_cmd = cfg_we && (cfg_addr == 3'd3) && cmd_bits[0] && !cmd_bits[1];

    p_ack_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        src_ack |-> (src_req && busy));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !src_ack));

    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (!mem_we || mem_addr == AW'($past(mem_addr) + 1'b1)));

    p_fill_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !src_ack) |-> (mem_wdata == FILL));

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ack && mem_we && !arm_cmd) |=> (xfer == CW'($past(xfer) + 1'b1)));

    p_len_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ack && !mem_we) |=> len_done);

    p_irq_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !busy);

    p_rearm_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_cmd && busy) |=> (err && busy));

endmodule

bind rx_dma_framer rxdma_checker #(.AW(AW), .CW(CW), .FILL(FILL)) u_rxdma_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cmd_bits  (cfg_wdata[1:0]),
    .src_req   (src_req),
    .src_ack   (src_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .irq       (irq),
    .busy      (eng_busy),
    .xfer      (eng_xfer),
    .len_done  (eng_len_done),
    .err       (eng_err)
);

// File: tb/test_rx_dma_framer.sv
`timescale 1ns/1ps
module test_rx_dma_framer;

    localparam int         AW    = 16;
    localparam int         BLOCK = 256;
    localparam logic [7:0] FILL  = 8'hA5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          src_req = 1'b0;
    logic [7:0]    src_data = '0;
    logic          src_eom = 1'b0;
    logic          src_ack;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          irq;

    always #2 clk = ~clk;

    rx_dma_framer #(.AW(AW), .CW(16), .BLOCK(BLOCK), .FILL(FILL)) i_rx_dma_framer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_req(src_req),
        .src_data(src_data), .src_eom(src_eom), .src_ack(src_ack),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    int total = 0;
    int failed = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 length, 2 receive, 3 pad
    int mph = 0, mmode = 0, maddr = 0, mrem = 0, mxfer = 0;
    int mirq = 0, merr = 0, mlen = 0;
    int rmode = 0, rbase = 0, rlimit = 0;

    always @(posedge clk) begin
        int oph;
        bit hit;
        if (!rst_n) begin
            mph = 0; mmode = 0; maddr = 0; mrem = 0; mxfer = 0;
            mirq = 0; merr = 0; mlen = 0; rmode = 0; rbase = 0; rlimit = 0;
        end else begin
            oph = mph;
            hit = cfg_we && cfg_addr == 3'd3;
            if (hit && cfg_wdata[2]) begin mirq = 0; merr = 0; end
            if (oph == 2 && src_req) begin
                maddr = (maddr + 1) % 65536; mxfer++; mrem--;
                if (mrem == 0) begin mph = 0; mirq = 1; end
                else if (mmode == 0 && src_eom) mph = 3;
            end else if (oph == 3) begin
                maddr = (maddr + 1) % 65536; mrem--;
                if (mrem == 0) begin mph = 0; mirq = 1; end
            end else if (oph == 1 && src_req) begin
                mlen = 1;
                if (src_data == 0) begin mph = 0; mirq = 1; end
                else begin mph = 2; mrem = src_data; end
            end
            if (hit && cfg_wdata[1]) mph = 0;
            else if (hit && cfg_wdata[0]) begin
                if (oph != 0) merr = 1;
                else begin
                    mmode = rmode; maddr = rbase; mxfer = 0; mlen = 0;
                    if (rmode == 1) mph = 1;
                    else if (rmode == 2) begin
                        mrem = rlimit;
                        if (rlimit == 0) begin mph = 0; mirq = 1; end else mph = 2;
                    end else begin mrem = BLOCK; mph = 2; end
                end
            end
            if (cfg_we && cfg_addr == 3'd0) rmode = cfg_wdata[1] ? 2 : (cfg_wdata[0] ? 1 : 0);
            if (cfg_we && cfg_addr == 3'd1) rbase = int'(cfg_wdata[15:0]);
            if (cfg_we && cfg_addr == 3'd2) rlimit = int'(cfg_wdata[15:0]);
        end
    end

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        bit e_ack, e_we;
        #1;
        if (rst_n) begin
            e_ack = src_req && (mph == 1 || mph == 2);
            e_we  = (mph == 2 && src_req) || mph == 3;
            check(src_ack == e_ack, "R11 ack", src_ack, e_ack);
            check(mem_we == e_we, "R3 write enable", mem_we, e_we);
            check(irq == mirq[0], "R5 irq", irq, mirq);
            if (e_we) begin
                check(int'(mem_addr) == maddr, "R8 address", mem_addr, maddr);
                check(mem_wdata == ((mph == 3) ? FILL : src_data), "R3 data", mem_wdata,
                      (mph == 3) ? FILL : src_data);
            end
        end
    end

    // memory sink
    logic [7:0] img [int];
    int nwr = 0, npad = 0;
    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            img[int'(mem_addr)] = mem_wdata;
            nwr++;
            if (!src_ack) npad++;
        end
    end

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
    endtask

    task automatic send_msg(input logic [7:0] q[$], input bit eom_last, input bit gaps);
        foreach (q[i]) begin
            @(negedge clk);
            if (gaps && (i % 3 == 2)) begin src_req = 1'b0; @(negedge clk); end
            src_req = 1'b1; src_data = q[i]; src_eom = eom_last && (i == q.size() - 1);
            #1;
            while (!src_ack) begin @(negedge clk); #1; end
        end
        @(negedge clk); src_req = 1'b0; src_eom = 1'b0;
    endtask

    task automatic wait_irq();
        while (!irq) @(negedge clk);
    endtask

    task automatic reset_sink();
        @(negedge clk); img.delete(); nwr = 0; npad = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog: actual 150000 cycles expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  msg[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            cfg_read(3'(a), rd);
            check(rd == 0, "R1 register reset", rd, 0);
        end
        check(irq == 0 && mem_we == 0 && src_ack == 0, "R1 outputs", {irq, mem_we, src_ack}, 0);

        // R2 register map
        cfg_write(3'd0, 32'd1); cfg_read(3'd0, rd); check(rd == 1, "R2 mode length", rd, 1);
        cfg_write(3'd0, 32'd3); cfg_read(3'd0, rd); check(rd == 2, "R2 mode decode", rd, 2);
        cfg_write(3'd1, 32'h0100); cfg_read(3'd1, rd); check(rd == 32'h100, "R2 base", rd, 32'h100);
        cfg_write(3'd2, 32'd77); cfg_read(3'd2, rd); check(rd == 77, "R2 limit", rd, 77);

        // R3 padded block, short message with gaps
        cfg_write(3'd0, 32'd0); reset_sink();
        cfg_write(3'd3, 32'h1);
        msg = {};
        for (int i = 0; i < 10; i++) msg.push_back(8'(8'h30 + i));
        send_msg(msg, 1'b1, 1'b1);
        wait_irq();
        check(nwr == BLOCK, "R3 block size", nwr, BLOCK);
        check(npad == BLOCK - 10, "R3 fill count", npad, BLOCK - 10);
        for (int i = 0; i < 10; i++)
            check(img[32'h100 + i] == msg[i], "R8 payload placement", img[32'h100 + i], msg[i]);
        check(img[32'h100 + 10] == FILL && img[32'h1FF] == FILL, "R3 fill value",
              img[32'h1FF], FILL);
        cfg_read(3'd4, rd); check(rd == 10, "R7 payload count", rd, 10);
        cfg_read(3'd3, rd); check(rd[1:0] == 2'b10, "R3 done status", rd[1:0], 2'b10);
        cfg_write(3'd3, 32'h4);
        cfg_read(3'd3, rd); check(rd[1] == 0 && irq == 0, "R9 clear", rd[1], 0);

        // R4 full block without end flag
        reset_sink(); cfg_write(3'd1, 32'h0400); cfg_write(3'd3, 32'h1);
        msg = {};
        for (int i = 0; i < BLOCK; i++) msg.push_back(8'(i ^ 8'h5A));
        send_msg(msg, 1'b0, 1'b0);
        wait_irq();
        check(nwr == BLOCK && npad == 0, "R4 no fill", npad, 0);
        check(img[32'h4FF] == msg[BLOCK - 1], "R4 last byte", img[32'h4FF], msg[BLOCK - 1]);
        cfg_write(3'd3, 32'h4);

        // R5 length prefix
        reset_sink(); cfg_write(3'd0, 32'd1); cfg_write(3'd1, 32'h0800); cfg_write(3'd3, 32'h1);
        msg = {8'd5};
        send_msg(msg, 1'b0, 1'b0);
        cfg_read(3'd3, rd);
        check(rd[2] == 1 && rd[1] == 0 && rd[0] == 1, "R5 length phase", rd[3:0], 4'b0101);
        check(nwr == 0, "R5 length byte not stored", nwr, 0);
        msg = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        send_msg(msg, 1'b1, 1'b1);
        wait_irq();
        check(nwr == 5 && npad == 0, "R5 payload count", nwr, 5);
        check(img[32'h800] == 8'h11 && img[32'h804] == 8'h55, "R5 payload bytes",
              img[32'h800], 8'h11);
        cfg_read(3'd4, rd); check(rd == 5, "R7 length payload count", rd, 5);
        cfg_write(3'd3, 32'h4);
        reset_sink(); cfg_write(3'd3, 32'h1);
        msg = {8'd0};
        send_msg(msg, 1'b0, 1'b0);
        check(irq == 1 && nwr == 0, "R5 zero length", {irq, 8'(nwr)}, 9'h100);
        cfg_write(3'd3, 32'h4);

        // R6 open count
        reset_sink(); cfg_write(3'd0, 32'd2); cfg_write(3'd1, 32'h0C00);
        cfg_write(3'd2, 32'd100); cfg_write(3'd3, 32'h1);
        msg = {};
        for (int i = 0; i < 10; i++) msg.push_back(8'(i + 1));
        send_msg(msg, 1'b1, 1'b0);
        send_msg(msg, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        cfg_read(3'd4, rd); check(rd == 20, "R7 readback mid-transfer", rd, 20);
        cfg_read(3'd3, rd); check(rd[1:0] == 2'b01 && npad == 0, "R6 still busy", rd[1:0], 2'b01);

        // R9 rearm while busy
        cfg_write(3'd3, 32'h1);
        cfg_read(3'd3, rd); check(rd[3] == 1 && rd[0] == 1, "R9 rearm error", rd[3:0], 4'b1001);
        cfg_read(3'd4, rd); check(rd == 20, "R9 count untouched", rd, 20);
        msg = {8'hEE};
        send_msg(msg, 1'b0, 1'b0);
        check(nwr == 21 && img[32'h0C00 + 20] == 8'hEE, "R9 transfer continues", nwr, 21);

        // R10 stop
        cfg_write(3'd3, 32'h2);
        cfg_read(3'd3, rd); check(rd[1:0] == 2'b00 && irq == 0, "R10 stop", rd[1:0], 0);
        cfg_write(3'd3, 32'h4);
        cfg_read(3'd3, rd); check(rd[3] == 0, "R9 error cleared", rd[3], 0);

        // R6 terminal count reached
        reset_sink(); cfg_write(3'd2, 32'd3); cfg_write(3'd3, 32'h1);
        msg = {8'h01, 8'h02, 8'h03};
        send_msg(msg, 1'b0, 1'b0);
        check(irq == 1 && nwr == 3, "R6 limit reached", nwr, 3);

        // R11 request while idle
        @(negedge clk); src_req = 1'b1; src_data = 8'h99;
        for (int i = 0; i < 4; i++) begin
            #1; check(src_ack == 0 && mem_we == 0, "R11 idle request", src_ack, 0);
            @(negedge clk);
        end
        src_req = 1'b0;
        check(nwr == 3, "R11 no idle write", nwr, 3);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule